// File: doc/BRIEF.md
# Radio Transceiver Interrupt Status Aggregator

This block gathers the interrupt sources of a small radio transceiver into one six-bit status word and drives a single active-high interrupt request. The sources are power-on reset, FIFO or transmit-register ready, overrun or underrun, wake-up timer expiry, an external interrupt pin and low supply detect. Each source has its own rule for setting and clearing. Some bits clear when software reads the status word. One bit follows its pin. One drops its request on a read but keeps its status bit while the fault lasts. The FIFO pair clears only when the function that raised it is turned off or drained.

Software reads the status through a one-cycle strobe. On that strobe the current word is frozen into a snapshot, and the bits that can be cleared by a read are cleared one cycle later. Only bits that appear in the snapshot are cleared, so an event that arrives during the read is not lost. The serial command path, the FIFO datapath, the radio and the supply comparator are outside the block. They appear only as plain inputs: event pulses, enable levels, a bit-read pulse and a supply-low level.

Top module: `irq_status_agg`

## Requirements
- R1: After reset the status word is 6'b100000 (only the power-on bit set), the snapshot is 0 and `irq` is 1.
- R2: The status bit order is [5] power-on, [4] FIFO/ready, [3] overrun/underrun, [2] wake-up, [1] external, [0] low supply. `irq` is the OR of the active requests and is 0 when none is active.
- R3: When `stat_rd` is high, the status word is captured into `snap` at that clock edge. Read-clearable bits that are set in `snap` clear at the following edge. A source event that arrives in the strobe cycle is not captured in `snap` and stays set in the status word.
- R4: The power-on bit is cleared by a status read.
- R5: An `ev_wkt` pulse sets the wake-up bit and its request one cycle later. A status read clears them.
- R6: The external bit equals `ext_pin` delayed by one clock, with no latching. A status read does not affect it.
- R7: While `lbd_en` and `vlow` are both high, the low-supply bit is set. A request is raised when this condition starts. A read drops the request, but the bit stays set while the condition holds. After `vlow` falls, the bit stays set until the next read clears it.
- R8: In transmit mode (`tx_en` and `txlatch_en` both high), `ev_ovr` sets bits 4 and 3 together and `ev_fifo` sets bit 4 alone. Both bits drive the request and ignore reads. They clear one cycle after `tx_en` or `txlatch_en` goes low.
- R9: In receive mode (`tx_en` low, `rx_en` and `rxfifo_en` high), `ev_ovr` sets bits 4 and 3 together and `ev_fifo` sets bit 4. A read clears both bits, but the receive request stays active.
- R10: The receive request clears after `RD_THR` `bit_rd` pulses. It also clears one cycle after `rx_en` or `rxfifo_en` goes low.
- R11: A source whose enable is low never sets its bit: `wkt_en` gates the wake-up timer, `lbd_en` gates low supply, and the transmit or receive mode enables gate the FIFO pair.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stat_rd | input | 1 | Status read strobe |
| tx_en | input | 1 | Transmitter enabled |
| txlatch_en | input | 1 | Transmit data latch enabled |
| rx_en | input | 1 | Receiver enabled |
| rxfifo_en | input | 1 | Receive FIFO enabled |
| wkt_en | input | 1 | Wake-up timer enabled |
| lbd_en | input | 1 | Low supply detector enabled |
| ev_fifo | input | 1 | FIFO threshold / transmit register ready pulse |
| ev_ovr | input | 1 | Overrun or underrun pulse |
| ev_wkt | input | 1 | Wake-up timer expiry pulse |
| bit_rd | input | 1 | One receive FIFO bit read |
| ext_pin | input | 1 | External interrupt level |
| vlow | input | 1 | Supply below threshold level |
| status | output | 6 | Live status word |
| snap | output | 6 | Status captured on the last read |
| irq | output | 1 | Interrupt request, active high |

## Verification
The assertions check the per-cycle rules on every cycle:
- a quiet `irq` means the power-on, wake-up and external bits are clear;
- the external bit follows its pin;
- the power-on and wake-up bits clear after a read that captured them;
- a disabled wake-up timer never raises its bit;
- low supply holds its bit;
- the transmit pair holds while its mode is on and drops when the mode is off;
- the receive request holds until a bit read or a disable ends it.

Only the bench scenarios can show the ordered behaviours. These are: a request that clears after exactly the threshold count of bit reads; an event that lands in the strobe cycle and survives the read; and the low-supply bit that stays set after recovery until a second read clears it.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
  localparam int NSRC   = 6;
  localparam int B_POR  = 5;
  localparam int B_FIFO = 4;
  localparam int B_OVR  = 3;
  localparam int B_WKT  = 2;
  localparam int B_EXT  = 1;
  localparam int B_LBD  = 0;

  typedef logic [NSRC-1:0] stat_t;

  // set has priority over clear
  function automatic logic sticky_next(input logic q, input logic set, input logic clr);
    return set | (q & ~clr);
  endfunction

  // last bit read of a threshold group
  function automatic logic thr_last(input int unsigned cnt, input int unsigned thr);
    return cnt == thr - 1;
  endfunction
endpackage

// File: rtl/irq_sticky_bit.sv
module irq_sticky_bit
  import irq_agg_pkg::*;
#(
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_o <= RST_VAL;
    else        q_o <= sticky_next(q_o, set_i, clr_i);
  end
endmodule

// File: rtl/irq_lbd_unit.sv
module irq_lbd_unit
  import irq_agg_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic lbd_en,
  input  logic vlow,
  input  logic clr_i,
  output logic st_o,
  output logic req_o
);
  logic cond, cond_q, onset;

  assign cond  = lbd_en & vlow;
  assign onset = cond & ~cond_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cond_q <= 1'b0;
      st_o   <= 1'b0;
      req_o  <= 1'b0;
    end else begin
      cond_q <= cond;
      st_o   <= sticky_next(st_o, cond, clr_i);
      req_o  <= sticky_next(req_o, onset, clr_i);
    end
  end
endmodule

// File: rtl/irq_fifo_unit.sv
module irq_fifo_unit
  import irq_agg_pkg::*;
#(
  parameter int RD_THR = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tx_en,
  input  logic txlatch_en,
  input  logic rx_en,
  input  logic rxfifo_en,
  input  logic ev_fifo,
  input  logic ev_ovr,
  input  logic bit_rd,
  input  logic clr_fifo_i,
  input  logic clr_ovr_i,
  output logic fifo_o,
  output logic ovr_o,
  output logic tx_owned_o,
  output logic rx_req_o
);
  localparam int CW = $clog2(RD_THR + 1);

  logic          tx_act, rx_act, any_ev, set_fifo, set_ovr;
  logic          tx_drop, clr_f, clr_o, rx_set, thr_done, rx_stop;
  logic [CW-1:0] cnt;

  assign tx_act   = tx_en & txlatch_en;
  assign rx_act   = ~tx_en & rx_en & rxfifo_en;
  assign any_ev   = ev_fifo | ev_ovr;
  assign set_fifo = (tx_act | rx_act) & any_ev;
  assign set_ovr  = (tx_act | rx_act) & ev_ovr;
  assign tx_drop  = tx_owned_o & ~tx_act;
  assign clr_f    = tx_owned_o ? tx_drop : clr_fifo_i;
  assign clr_o    = tx_owned_o ? tx_drop : clr_ovr_i;
  assign rx_set   = rx_act & any_ev;
  assign thr_done = rx_req_o & bit_rd & thr_last(int'(cnt), RD_THR);
  assign rx_stop  = ~rx_en | ~rxfifo_en | thr_done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fifo_o     <= 1'b0;
      ovr_o      <= 1'b0;
      tx_owned_o <= 1'b0;
      rx_req_o   <= 1'b0;
      cnt        <= '0;
    end else begin
      fifo_o     <= sticky_next(fifo_o, set_fifo, clr_f);
      ovr_o      <= sticky_next(ovr_o, set_ovr, clr_o);
      tx_owned_o <= sticky_next(tx_owned_o, tx_act & set_fifo, tx_drop);
      rx_req_o   <= sticky_next(rx_req_o, rx_set, rx_stop);
      if (rx_set || !rx_req_o || rx_stop) cnt <= '0;
      else if (bit_rd)                    cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/irq_status_agg.sv
module irq_status_agg
  import irq_agg_pkg::*;
#(
  parameter int RD_THR = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            stat_rd,
  input  logic            tx_en,
  input  logic            txlatch_en,
  input  logic            rx_en,
  input  logic            rxfifo_en,
  input  logic            wkt_en,
  input  logic            lbd_en,
  input  logic            ev_fifo,
  input  logic            ev_ovr,
  input  logic            ev_wkt,
  input  logic            bit_rd,
  input  logic            ext_pin,
  input  logic            vlow,
  output logic [NSRC-1:0] status,
  output logic [NSRC-1:0] snap,
  output logic            irq
);
  stat_t clr_vec;
  logic  clr_q, ext_q;
  logic  por_st, wkt_st, fifo_st, ovr_st, lbd_st;
  logic  lbd_req, tx_owned, rx_req;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      snap  <= '0;
      clr_q <= 1'b0;
      ext_q <= 1'b0;
    end else begin
      if (stat_rd) snap <= status;
      clr_q <= stat_rd;
      ext_q <= ext_pin;
    end
  end

  assign clr_vec = {NSRC{clr_q}} & snap;

  irq_sticky_bit #(.RST_VAL(1'b1)) u_por (
    .clk(clk), .rst_n(rst_n), .set_i(1'b0), .clr_i(clr_vec[B_POR]), .q_o(por_st));

  irq_sticky_bit #(.RST_VAL(1'b0)) u_wkt (
    .clk(clk), .rst_n(rst_n), .set_i(ev_wkt & wkt_en), .clr_i(clr_vec[B_WKT]), .q_o(wkt_st));

  irq_lbd_unit u_lbd (
    .clk(clk), .rst_n(rst_n), .lbd_en(lbd_en), .vlow(vlow),
    .clr_i(clr_vec[B_LBD]), .st_o(lbd_st), .req_o(lbd_req));

  irq_fifo_unit #(.RD_THR(RD_THR)) u_fifo (
    .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .txlatch_en(txlatch_en),
    .rx_en(rx_en), .rxfifo_en(rxfifo_en), .ev_fifo(ev_fifo), .ev_ovr(ev_ovr),
    .bit_rd(bit_rd), .clr_fifo_i(clr_vec[B_FIFO]), .clr_ovr_i(clr_vec[B_OVR]),
    .fifo_o(fifo_st), .ovr_o(ovr_st), .tx_owned_o(tx_owned), .rx_req_o(rx_req));

  always_comb begin
    status         = '0;
    status[B_POR]  = por_st;
    status[B_FIFO] = fifo_st;
    status[B_OVR]  = ovr_st;
    status[B_WKT]  = wkt_st;
    status[B_EXT]  = ext_q;
    status[B_LBD]  = lbd_st;
  end

  assign irq = por_st | wkt_st | ext_q | lbd_req | rx_req | (tx_owned & (fifo_st | ovr_st));
endmodule

// File: rtl/irq_status_agg_chk.sv
module irq_status_agg_chk
  import irq_agg_pkg::*;
(
  input logic            clk,
  input logic            rst_n,
  input logic            stat_rd,
  input logic            tx_en,
  input logic            txlatch_en,
  input logic            rx_en,
  input logic            rxfifo_en,
  input logic            wkt_en,
  input logic            lbd_en,
  input logic            ev_fifo,
  input logic            ev_ovr,
  input logic            ev_wkt,
  input logic            bit_rd,
  input logic            ext_pin,
  input logic            vlow,
  input logic [NSRC-1:0] status,
  input logic [NSRC-1:0] snap,
  input logic            irq,
  input logic            tx_owned,
  input logic            rx_req
);
  logic seen;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seen <= 1'b0;
    else        seen <= 1'b1;
  end

  AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !irq |-> (!status[B_POR] && !status[B_WKT] && !status[B_EXT])); // R2
  AST_EXT_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
    seen |-> (status[B_EXT] == $past(ext_pin))); // R6
  AST_POR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && $past(stat_rd) && snap[B_POR]) |=> !status[B_POR]); // R4
  AST_WKT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && $past(stat_rd) && snap[B_WKT] && !(wkt_en && ev_wkt)) |=> !status[B_WKT]); // R5
  AST_WKT_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    (!wkt_en && !status[B_WKT]) |=> !status[B_WKT]); // R11
  AST_LBD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (lbd_en && vlow) |=> status[B_LBD]); // R7
  AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_owned && tx_en && txlatch_en) |=> (status[B_FIFO] && tx_owned)); // R8
  AST_TX_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_owned && !(tx_en && txlatch_en) && !ev_fifo && !ev_ovr) |=> !status[B_FIFO]); // R8
  AST_RX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_req && rx_en && rxfifo_en && !bit_rd) |=> rx_req); // R9
  AST_RX_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en |=> !rx_req); // R10
endmodule

bind irq_status_agg irq_status_agg_chk u_chk (
  .clk(clk), .rst_n(rst_n), .stat_rd(stat_rd), .tx_en(tx_en), .txlatch_en(txlatch_en),
  .rx_en(rx_en), .rxfifo_en(rxfifo_en), .wkt_en(wkt_en), .lbd_en(lbd_en),
  .ev_fifo(ev_fifo), .ev_ovr(ev_ovr), .ev_wkt(ev_wkt), .bit_rd(bit_rd),
  .ext_pin(ext_pin), .vlow(vlow), .status(status), .snap(snap), .irq(irq),
  .tx_owned(tx_owned), .rx_req(rx_req));

// File: tb/test_irq_status_agg.sv
module test_irq_status_agg;
  localparam int CLK_PERIOD = 10;
  localparam int THR = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic stat_rd = 0, tx_en = 0, txlatch_en = 0, rx_en = 0, rxfifo_en = 0;
  logic wkt_en = 0, lbd_en = 0, ev_fifo = 0, ev_ovr = 0, ev_wkt = 0;
  logic bit_rd = 0, ext_pin = 0, vlow = 0;
  logic [5:0] status, snap;
  logic irq;
  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_status_agg #(.RD_THR(THR)) i_irq_status_agg (
    .clk(clk), .rst_n(rst_n), .stat_rd(stat_rd), .tx_en(tx_en), .txlatch_en(txlatch_en),
    .rx_en(rx_en), .rxfifo_en(rxfifo_en), .wkt_en(wkt_en), .lbd_en(lbd_en),
    .ev_fifo(ev_fifo), .ev_ovr(ev_ovr), .ev_wkt(ev_wkt), .bit_rd(bit_rd),
    .ext_pin(ext_pin), .vlow(vlow), .status(status), .snap(snap), .irq(irq));

  task automatic chk(input string tag, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_read();
    stat_rd = 1; step(); stat_rd = 0; step();
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      n_fail++; n_run++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 status", status, 6'b100000);
    chk("R1 snap", snap, 0);
    chk("R1 irq", irq, 1);
    rst_n = 1; step();
    do_read();
    chk("R3 snap", snap, 6'b100000);
    chk("R4 por cleared", status, 0);
    chk("R2 irq idle", irq, 0);

    // wake-up timer, enable swept
    for (int en = 0; en < 2; en++) begin
      wkt_en = en[0]; ev_wkt = 1; step(); ev_wkt = 0;
      chk("R5/R11 wkt bit", status[2], en);
      chk("R2 irq wkt", irq, en);
      do_read();
      chk("R5 wkt cleared", status[2], 0);
    end

    // event in strobe cycle survives the read
    wkt_en = 1; stat_rd = 1; ev_wkt = 1; step(); stat_rd = 0; ev_wkt = 0;
    chk("R3 snap misses event", snap[2], 0);
    chk("R3 bit set", status[2], 1);
    step();
    chk("R3 event kept", status[2], 1);
    do_read();
    chk("R5 cleared later", status[2], 0);

    // external pin pattern
    for (int k = 0; k < 8; k++) begin
      logic p;
      p = ((8'b10110010 >> k) & 1) != 0;
      ext_pin = p; step();
      chk("R6 ext follow", status[1], p);
      chk("R2 irq ext", irq, p);
    end
    ext_pin = 1; step(); do_read();
    chk("R6 read no effect", status[1], 1);
    ext_pin = 0; step();

    // low supply
    lbd_en = 0; vlow = 1; step(); step();
    chk("R11 lbd gated", status[0], 0);
    lbd_en = 1; step();
    chk("R7 lbd set", status[0], 1);
    chk("R7 lbd irq", irq, 1);
    do_read();
    chk("R7 bit held", status[0], 1);
    chk("R7 req released", irq, 0);
    vlow = 0; step();
    chk("R7 bit kept after recovery", status[0], 1);
    do_read();
    chk("R7 bit cleared", status[0], 0);
    lbd_en = 0;

    // transmit mode, drop cause swept
    for (int k = 0; k < 2; k++) begin
      tx_en = 1; txlatch_en = 1;
      ev_ovr = 1; step(); ev_ovr = 0;
      chk("R8 pair set", status[4:3], 2'b11);
      chk("R8 irq", irq, 1);
      do_read();
      chk("R8 read ignored", status[4:3], 2'b11);
      if (k == 0) tx_en = 0; else txlatch_en = 0;
      step();
      chk("R8 drop clears", status[4:3], 0);
      chk("R8 irq off", irq, 0);
    end
    tx_en = 1; txlatch_en = 1; ev_fifo = 1; step(); ev_fifo = 0;
    chk("R8 fifo only", status[4:3], 2'b10);
    tx_en = 0; txlatch_en = 0; step();

    // receive gating
    ev_fifo = 1; step(); ev_fifo = 0;
    chk("R11 rx gated", status[4], 0);

    // receive mode, threshold count
    rx_en = 1; rxfifo_en = 1;
    ev_ovr = 1; step(); ev_ovr = 0;
    chk("R9 pair set", status[4:3], 2'b11);
    do_read();
    chk("R9 read clears bits", status[4:3], 0);
    chk("R9 req held", irq, 1);
    for (int n = 1; n <= THR; n++) begin
      bit_rd = 1; step(); bit_rd = 0;
      chk("R10 threshold count", irq, (n < THR) ? 1 : 0);
    end

    // receive request stop by disables
    for (int k = 0; k < 2; k++) begin
      rx_en = 1; rxfifo_en = 1;
      ev_fifo = 1; step(); ev_fifo = 0;
      chk("R10 req on", irq, 1);
      if (k == 0) rx_en = 0; else rxfifo_en = 0;
      step();
      chk("R10 disable stops req", irq, 0);
      do_read();
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule